// File: doc/BRIEF.md
# Gated Clock Fan-out Core with Half-Rate Bank

This block is the digital heart of a clock distribution buffer. A static select line picks one of two incoming clocks. The chosen clock is then gated by an enable request that is retimed inside the block against that same clock, so the gate can only open or close while the clock is low. Because of this, turning the outputs on or off never produces a shortened pulse.

The gated clock feeds two banks of true/complement output pairs. Bank A runs at the rate of the selected clock. Bank B runs at half that rate, taken from a toggle stage that advances only on enabled rising edges. When the outputs are stopped, each pair parks with its true leg low and its complement leg high.

An active-high master reset acts at once, without waiting for a clock. It clears the divider and the enable path, and it parks every pair whatever the select and enable inputs are. The release of the reset is retimed to the selected clock, so the divider restarts cleanly on a later rising edge. The select line is expected to change only while master reset is held.

Top module: `clkfan_core`

## Requirements
- R1: `sel_sec` = 1 routes `clk_sec` to the outputs, and `sel_sec` = 0 routes `clk_pri`. When enabled, the high time of bank A equals the high time of the routed clock.
- R2: While the gate is open, every bank A true output equals the selected clock without inversion: high during the clock's high phase and low during its low phase.
- R3: While the gate is closed, every true output of both banks is 0 and every complement output is 1.
- R4: The value of `en_req` sampled at a rising edge of the selected clock opens or closes the gate at the falling edge that follows. Output behaviour from that falling edge onward follows that sampled value.
- R5: Outside master reset, no true output produces a high or low interval shorter than half a period of the selected clock.
- R6: Bank B toggles on each rising edge at which the gate is open, so it runs at half the bank A rate. When the gate is closed, bank B is forced to 0 and its toggle stage is cleared, so the first open rising edge after reset or re-enable drives bank B high.
- R7: Every complement output is the logical inverse of its true output at all times, including during reset.
- R8: A high level on `master_rst` parks all outputs (R3 levels) immediately, without waiting for a clock edge, and clears the divider.
- R9: After `master_rst` falls, the enable path stays cleared through RST_STAGES (default 2) rising edges of the selected clock. `en_req` is first sampled at the next rising edge after those.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary input clock (routed when `sel_sec` = 0) |
| clk_sec | input | 1 | Secondary input clock (routed when `sel_sec` = 1) |
| sel_sec | input | 1 | Static source select, 1 chooses `clk_sec` |
| en_req | input | 1 | Output enable request, asynchronous to the clocks |
| master_rst | input | 1 | Active-high master reset, asynchronous assertion |
| bank_a_t | output | OUTS_A | Full-rate true outputs |
| bank_a_c | output | OUTS_A | Full-rate complement outputs |
| bank_b_t | output | OUTS_B | Half-rate true outputs |
| bank_b_c | output | OUTS_B | Half-rate complement outputs |

## Verification
The hardest case to reach is an enable change that lands in the middle of a bank B high interval, or just after a rising edge, where a naive gate would chop a pulse. The stimulus toggles `en_req` hundreds of times after random numbers of clock edges, under both clock sources. A cycle model predicts the level of every pair just after each edge, and every output interval is measured against half the selected period. Master reset is also asserted in the middle of a clock high phase, and its release count is checked against the first edge at which the enable is sampled.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

  localparam int unsigned DEF_OUTS_A     = 2;
  localparam int unsigned DEF_OUTS_B     = 2;
  localparam int unsigned DEF_RST_STAGES = 2;

  typedef enum logic {
    SRC_PRIMARY   = 1'b0,
    SRC_SECONDARY = 1'b1
  } src_e;

endpackage

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux
  import clkfan_pkg::*;
(
  input  logic clk_pri,
  input  logic clk_sec,
  input  logic sel_sec,
  output logic clk_o
);

  src_e src_sel;

  always_comb begin
    src_sel = src_e'(sel_sec);
  end

  // static select: a plain mux is enough, switching happens under reset
  always_comb begin
    if (src_sel == SRC_SECONDARY) begin
      clk_o = clk_sec;
    end else begin
      clk_o = clk_pri;
    end
  end

endmodule

// File: rtl/clkfan_rst_sync.sv
module clkfan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_d;
  logic [STAGES-1:0] sync_q;

  // next state: shift a one in from the bottom
  always_comb begin
    sync_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  // assertion is immediate, release walks through the stages
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[LAST];

endmodule

// File: rtl/clkfan_en_retime.sv
module clkfan_en_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic en_live
);

  logic cap_d;
  logic cap_q;
  logic live_d;
  logic live_q;

  always_comb begin
    cap_d  = en_req;
    live_d = cap_q;
  end

  // first stage: rising-edge sample of the asynchronous request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
    end
  end

  // second stage: falling-edge capture, so the gate moves while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= live_d;
    end
  end

  assign en_live = live_q;

endmodule

// File: rtl/clkfan_div2.sv
module clkfan_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic en_live,
  output logic div_q
);

  logic tog_d;
  logic tog_q;

  // advance only while the gate is open, otherwise hold cleared
  always_comb begin
    if (en_live) begin
      tog_d = ~tog_q;
    end else begin
      tog_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
    end
  end

  assign div_q = tog_q;

endmodule

// File: rtl/clkfan_bank.sv
module clkfan_bank #(
  parameter int unsigned OUTS = 2
) (
  input  logic            src,
  input  logic            gate_on,
  output logic [OUTS-1:0] q_t,
  output logic [OUTS-1:0] q_c
);

  logic gated;

  always_comb begin
    gated = src & gate_on;
  end

  for (genvar g = 0; g < OUTS; g++) begin : g_pair
    assign q_t[g] = gated;
    assign q_c[g] = ~gated;
  end

endmodule

// File: rtl/clkfan_core.sv
module clkfan_core
  import clkfan_pkg::*;
#(
  parameter int unsigned OUTS_A     = DEF_OUTS_A,
  parameter int unsigned OUTS_B     = DEF_OUTS_B,
  parameter int unsigned RST_STAGES = DEF_RST_STAGES
) (
  input  logic              clk_pri,
  input  logic              clk_sec,
  input  logic              sel_sec,
  input  logic              en_req,
  input  logic              master_rst,
  output logic [OUTS_A-1:0] bank_a_t,
  output logic [OUTS_A-1:0] bank_a_c,
  output logic [OUTS_B-1:0] bank_b_t,
  output logic [OUTS_B-1:0] bank_b_c
);

  logic sel_clk;
  logic rst_n;
  logic en_live;
  logic div_q;

  clkfan_src_mux u_mux (
    .clk_pri (clk_pri),
    .clk_sec (clk_sec),
    .sel_sec (sel_sec),
    .clk_o   (sel_clk)
  );

  clkfan_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (sel_clk),
    .arst  (master_rst),
    .rst_n (rst_n)
  );

  clkfan_en_retime u_en (
    .clk     (sel_clk),
    .rst_n   (rst_n),
    .en_req  (en_req),
    .en_live (en_live)
  );

  clkfan_div2 u_div (
    .clk     (sel_clk),
    .rst_n   (rst_n),
    .en_live (en_live),
    .div_q   (div_q)
  );

  clkfan_bank #(.OUTS(OUTS_A)) u_bank_a (
    .src     (sel_clk),
    .gate_on (en_live),
    .q_t     (bank_a_t),
    .q_c     (bank_a_c)
  );

  clkfan_bank #(.OUTS(OUTS_B)) u_bank_b (
    .src     (div_q),
    .gate_on (en_live),
    .q_t     (bank_b_t),
    .q_c     (bank_b_c)
  );

endmodule

// File: rtl/clkfan_core_chk.sv
module clkfan_core_chk #(
  parameter int unsigned OUTS_A = 2,
  parameter int unsigned OUTS_B = 2
) (
  input logic              sel_clk,
  input logic              rst_n,
  input logic              en_req,
  input logic              en_live,
  input logic              div_q,
  input logic [OUTS_A-1:0] bank_a_t,
  input logic [OUTS_B-1:0] bank_b_t
);

  logic armed_q;

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  // R4
  en_retime_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    armed_q |-> (en_live == $past(en_req)));

  // R6
  div_toggle_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (armed_q && en_live) |=> (div_q != $past(div_q)));

  // R6
  div_clear_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (armed_q && !en_live) |=> (div_q == 1'b0));

  // R2
  bank_a_follow_chk: assert property (@(negedge sel_clk) disable iff (!rst_n)
    en_live |-> (bank_a_t == {OUTS_A{1'b1}}));

  // R3
  park_level_chk: assert property (@(negedge sel_clk) disable iff (!rst_n)
    !en_live |-> ((bank_a_t == '0) && (bank_b_t == '0)));

endmodule

bind clkfan_core clkfan_core_chk #(.OUTS_A(OUTS_A), .OUTS_B(OUTS_B)) u_chk (
  .sel_clk  (sel_clk),
  .rst_n    (rst_n),
  .en_req   (en_req),
  .en_live  (en_live),
  .div_q    (div_q),
  .bank_a_t (bank_a_t),
  .bank_b_t (bank_b_t)
);

// File: tb/clkfan_core_bench.sv
module clkfan_core_bench;

  localparam int PERIOD_PRI = 10;
  localparam int PERIOD_SEC = 14;
  localparam int NA = 2;
  localparam int NB = 2;

  logic clk_pri = 1'b0;
  logic clk_sec = 1'b0;
  logic sel_sec = 1'b0;
  logic en_req = 1'b1;
  logic master_rst = 1'b1;
  logic [NA-1:0] bank_a_t, bank_a_c;
  logic [NB-1:0] bank_b_t, bank_b_c;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD_PRI/2) clk_pri = ~clk_pri;
  initial begin
    #3;
    forever #(PERIOD_SEC/2) clk_sec = ~clk_sec;
  end

  wire sclk = sel_sec ? clk_sec : clk_pri;

  clkfan_core u_clkfan_core (
    .clk_pri    (clk_pri),
    .clk_sec    (clk_sec),
    .sel_sec    (sel_sec),
    .en_req     (en_req),
    .master_rst (master_rst),
    .bank_a_t   (bank_a_t),
    .bank_a_c   (bank_a_c),
    .bank_b_t   (bank_b_t),
    .bank_b_c   (bank_b_c)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- expectation model (from the requirements) ----------------
  typedef struct { logic a; logic b; } exp_t;
  exp_t sb_q[$];

  logic m_pend = 1'b0;
  logic m_act  = 1'b0;
  logic m_bq   = 1'b0;
  int   m_rel  = 2;

  always @(posedge master_rst) begin
    m_act = 1'b0;
    m_pend = 1'b0;
    m_bq = 1'b0;
  end

  always @(posedge sclk) begin
    exp_t e;
    if (master_rst) begin
      m_rel = 2; m_pend = 1'b0; m_bq = 1'b0; m_act = 1'b0;
    end else if (m_rel > 0) begin
      m_rel--; m_pend = 1'b0; m_bq = 1'b0;
    end else begin
      m_bq = m_act ? ~m_bq : 1'b0;
      m_pend = en_req;
    end
    e.a = m_act;
    e.b = m_bq & m_act;
    sb_q.push_back(e);
  end

  always @(negedge sclk) begin
    exp_t e;
    m_act = master_rst ? 1'b0 : m_pend;
    e.a = 1'b0;
    e.b = m_bq & m_act;
    sb_q.push_back(e);
  end

  // ---------------- monitor: pops and compares ----------------
  always @(sclk) begin
    exp_t e;
    #2;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(bank_a_t == {NA{e.a}}, "R2 R3 R4 R9", "bank A true",
            int'(bank_a_t), int'({NA{e.a}}));
      check(bank_b_t == {NB{e.b}}, "R6 R3", "bank B true",
            int'(bank_b_t), int'({NB{e.b}}));
      check((bank_a_c == ~bank_a_t) && (bank_b_c == ~bank_b_t), "R7", "complement",
            int'({bank_a_c, bank_b_c}), int'({~bank_a_t, ~bank_b_t}));
    end
  end

  // ---------------- pulse width and edge counting ----------------
  time last_a = 0, last_b = 0;
  bit meas_a = 1'b0, meas_b = 1'b0;
  int viol_a = 0, viol_b = 0;
  int last_hi_a = 0;
  int rises_a = 0, rises_b = 0;

  always @(posedge master_rst) begin
    meas_a = 1'b0;
    meas_b = 1'b0;
  end

  always @(bank_a_t[0]) begin
    int w;
    int halfp;
    halfp = sel_sec ? PERIOD_SEC/2 : PERIOD_PRI/2;
    w = int'($time - last_a);
    if (meas_a && !master_rst) begin
      if (bank_a_t[0] == 1'b0) last_hi_a = w;
      if (w < halfp) viol_a++;
    end
    if (bank_a_t[0]) rises_a++;
    last_a = $time;
    meas_a = !master_rst;
  end

  always @(bank_b_t[0]) begin
    int w;
    int halfp;
    halfp = sel_sec ? PERIOD_SEC/2 : PERIOD_PRI/2;
    w = int'($time - last_b);
    if (meas_b && !master_rst) begin
      if (w < halfp) viol_b++;
    end
    if (bank_b_t[0]) rises_b++;
    last_b = $time;
    meas_b = !master_rst;
  end

  // ---------------- driver ----------------
  task automatic edges(input int n);
    repeat (n) @(posedge sclk);
  endtask

  task automatic do_reset(input bit sel, input bit en);
    edges(1);
    #3 master_rst = 1'b1;
    #1;
    check(bank_a_t == '0 && bank_b_t == '0 && bank_a_c == '1 && bank_b_c == '1,
          "R8", "parked right after reset rise", int'({bank_a_t, bank_b_t}), 0);
    sel_sec = sel;
    en_req = en;
    edges(4);
    #3 master_rst = 1'b0;
    rises_a = 0;
    rises_b = 0;
  endtask

  task automatic steady_phase(input int halfp, input string tag);
    edges(40);
    #1;
    check(last_hi_a == halfp, "R1", {tag, " bank A high time"}, last_hi_a, halfp);
    check(rises_b == (rises_a + 1) / 2, "R6", {tag, " B/A rise ratio"},
          rises_b, (rises_a + 1) / 2);
  endtask

  task automatic toggle_phase(input int n);
    for (int i = 0; i < n; i++) begin
      edges(1 + int'($urandom_range(0, 5)));
      if ($urandom_range(0, 1) == 1) begin
        #1 en_req = ~en_req;
      end else begin
        @(negedge sclk);
        #2 en_req = ~en_req;
      end
    end
  endtask

  initial begin
    #1;
    check(bank_a_t == '0 && bank_b_t == '0 && bank_a_c == '1 && bank_b_c == '1,
          "R8 R3", "reset state", int'({bank_a_t, bank_b_t}), 0);
    edges(4);
    #3 master_rst = 1'b0;
    rises_a = 0;
    rises_b = 0;
    steady_phase(PERIOD_PRI/2, "primary");
    toggle_phase(300);
    en_req = 1'b1;
    do_reset(1'b0, 1'b1);
    steady_phase(PERIOD_PRI/2, "primary after mid reset");
    en_req = 1'b0;
    edges(6);
    #1;
    check(bank_a_t == '0 && bank_a_c == '1, "R3", "parked while disabled",
          int'(bank_a_t), 0);
    do_reset(1'b1, 1'b1);
    steady_phase(PERIOD_SEC/2, "secondary");
    toggle_phase(300);
    do_reset(1'b1, 1'b0);
    edges(10);
    #1;
    check(bank_a_t == '0 && bank_b_t == '0, "R3", "secondary disabled park",
          int'({bank_a_t, bank_b_t}), 0);
    en_req = 1'b1;
    edges(20);
    check(viol_a == 0, "R5", "short pulses on bank A", viol_a, 0);
    check(viol_b == 0, "R5", "short pulses on bank B", viol_b, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(PERIOD_PRI * 150000);
    if (!done) begin
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule